// File: doc/BRIEF.md
# Two-Port GPIO Controller with Pin Interrupts

This block is a register-mapped controller for two 32-bit general-purpose I/O ports. Each port holds direction, output, pull-up, a dual-purpose pull-down/open-drain bit, drive and input-filter/slew settings. It also has a live input view and a write-to-clear path for the output latch. The pad side is reduced to the control signals a pad ring needs: output enable, output value, pull-up enable and pull-down enable.

Eight fixed pins also feed an interrupt unit. Each source has an enable, a level-or-edge mode and a polarity, and raises a sticky flag that software clears by writing ones. A single request line is high while any enabled source has its flag set. Software reaches everything through a word-addressed bus with per-byte write enables and a combinational read path.

Top module: `gpio_dual_port`

## Requirements
- R1: After reset, direction, output, pull-up, pull-down and drive registers read zero, the filter/slew register reads all ones, all four interrupt bytes read zero and `irq_o` is low.
- R2: Word address 16+k reaches port A register k and 24+k reaches port B register k. The order of k is: direction, input, output, output-clear, pull-up, pull-down/open-drain, drive, filter/slew. A write changes only the bytes whose `bus_be` bit is set.
- R3: Reading the input register returns the present level of the port's input pins.
- R4: Writing the output-clear register clears every output bit whose written bit is 1, in the enabled bytes. The output-clear register always reads zero.
- R5: A pin's output enable is high when its direction bit is 1 (output), except when its pull-down/open-drain bit and its output bit are both 1. The output value pin follows the output register.
- R6: The pull-down enable is high only for input pins (direction 0) whose pull-down/open-drain bit is 1. The pull-up enable follows the pull-up register.
- R7: Word address 7 holds the interrupt unit: byte 0 flags, byte 1 enables, byte 2 modes, byte 3 polarities. Bit positions 0 to 7 belong to pins A2, A3, A4, B3, B4, B11, B12, B15.
- R8: In level mode (mode bit 0), the flag is set on every cycle that the synchronized pin equals the polarity bit (0 low, 1 high).
- R9: In edge mode (mode bit 1), the flag is set once per transition toward the polarity level (0 falling, 1 rising). The pin passes a two-flop synchronizer, so a change made before clock edge n shows in the flag after edge n+2.
- R10: Writing 1 to a flag bit clears it and writing 0 leaves it. When a clear and a new event land on the same edge, the flag stays set.
- R11: A source can set its flag only while its enable bit is 1 and its pin's direction bit is 0.
- R12: `irq_o` is high exactly when some source has both its flag and its enable set. Clearing an enable drops the request but keeps the flag.
- R13: Unmapped word addresses read zero and ignore writes, and writes to the input registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 6 | Word address |
| bus_be | input | 4 | Byte write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pa_in | input | 32 | Port A pin levels |
| pa_oe | output | 32 | Port A output enables |
| pa_do | output | 32 | Port A output values |
| pa_pu | output | 32 | Port A pull-up enables |
| pa_pd | output | 32 | Port A pull-down enables |
| pb_in | input | 32 | Port B pin levels |
| pb_oe | output | 32 | Port B output enables |
| pb_do | output | 32 | Port B output values |
| pb_pu | output | 32 | Port B pull-up enables |
| pb_pd | output | 32 | Port B pull-down enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a software flag clear that lands on the same edge as a fresh edge event. The event trails the pin change by the synchronizer depth, so it cannot be lined up by watching outputs. The stimulus raises a rising-edge pin and then issues the clear after a swept delay of zero to four cycles. This places the clear before, on and after the setting edge, and the final flag is checked for each delay. A second hard spot is a level source that keeps re-setting its flag while software clears it. The stimulus covers this by clearing while the level is held and again after it is released.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;
  localparam int PORT_W   = 32;
  localparam int NPORT    = 2;
  localparam int NSRC     = 8;
  localparam int BUS_W    = 32;
  localparam int ADDR_W   = 6;
  localparam int LANES    = BUS_W / 8;
  localparam int GRP_BASE = 2;
  localparam logic [ADDR_W-1:0] IRQ_WORD = 6'd7;

  typedef enum logic [2:0] {
    RG_DIR  = 3'd0,
    RG_PIN  = 3'd1,
    RG_OUT  = 3'd2,
    RG_CLR  = 3'd3,
    RG_PU   = 3'd4,
    RG_PD   = 3'd5,
    RG_DRV  = 3'd6,
    RG_SMT  = 3'd7
  } port_reg_e;

  // Flat pin index (port*PORT_W + bit) of interrupt source k.
  function automatic int src_pin_idx(input int k);
    case (k)
      0:       return 2;
      1:       return 3;
      2:       return 4;
      3:       return PORT_W + 3;
      4:       return PORT_W + 4;
      5:       return PORT_W + 11;
      6:       return PORT_W + 12;
      default: return PORT_W + 15;
    endcase
  endfunction
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_dual_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   reg_sel,
  input  logic [W/8-1:0] be,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] rdata,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_do,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] pad_pd
);
  localparam int NB = W / 8;

  logic [W-1:0] dir_q, out_q, pu_q, pd_q, drv_q, smt_q;
  logic [W-1:0] dir_d, out_d, pu_d, pd_d, drv_d, smt_d;
  logic [W-1:0] bmask;

  always_comb begin
    for (int b = 0; b < NB; b++) bmask[b*8 +: 8] = {8{be[b]}};
  end

  function automatic logic [W-1:0] merge(input logic [W-1:0] cur,
                                         input logic [W-1:0] nw,
                                         input logic [W-1:0] m);
    return (cur & ~m) | (nw & m);
  endfunction

  always_comb begin
    dir_d = dir_q;
    out_d = out_q;
    pu_d  = pu_q;
    pd_d  = pd_q;
    drv_d = drv_q;
    smt_d = smt_q;
    if (wr_en) begin
      case (port_reg_e'(reg_sel))
        RG_DIR: dir_d = merge(dir_q, wdata, bmask);
        RG_OUT: out_d = merge(out_q, wdata, bmask);
        RG_CLR: out_d = out_q & ~(wdata & bmask);
        RG_PU:  pu_d  = merge(pu_q, wdata, bmask);
        RG_PD:  pd_d  = merge(pd_q, wdata, bmask);
        RG_DRV: drv_d = merge(drv_q, wdata, bmask);
        RG_SMT: smt_d = merge(smt_q, wdata, bmask);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      pu_q  <= '0;
      pd_q  <= '0;
      drv_q <= '0;
      smt_q <= '1;
    end else begin
      dir_q <= dir_d;
      out_q <= out_d;
      pu_q  <= pu_d;
      pd_q  <= pd_d;
      drv_q <= drv_d;
      smt_q <= smt_d;
    end
  end

  always_comb begin
    case (port_reg_e'(reg_sel))
      RG_DIR:  rdata = dir_q;
      RG_PIN:  rdata = pin_in;
      RG_OUT:  rdata = out_q;
      RG_PU:   rdata = pu_q;
      RG_PD:   rdata = pd_q;
      RG_DRV:  rdata = drv_q;
      RG_SMT:  rdata = smt_q;
      default: rdata = '0;
    endcase
  end

  assign dir_o  = dir_q;
  assign pad_oe = dir_q & ~(pd_q & out_q);
  assign pad_do = out_q;
  assign pad_pu = pu_q;
  assign pad_pd = pd_q & ~dir_q;

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & pad_do & pd_q) == '0));  // R5

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 3'(RG_CLR)) |=> ((out_q & $past(wdata & bmask)) == '0));  // R4

  AST_PIN_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 3'(RG_PIN)) |=> ($stable(dir_q) && $stable(out_q) && $stable(pd_q)));  // R13
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_dual_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LANES-1:0] be,
  input  logic [BUS_W-1:0] wdata,
  input  logic [N-1:0]     src_pin,
  input  logic [N-1:0]     src_in,
  output logic [BUS_W-1:0] rdata,
  output logic             irq
);
  logic [N-1:0] sync1_q, sync2_q, prev_q;
  logic [N-1:0] flag_q, en_q, mode_q, pol_q;
  logic [N-1:0] flag_d, en_d, mode_d, pol_d;
  logic [N-1:0] hit, edge_seen, event_v, clr_v;

  always_comb begin
    hit       = ~(sync2_q ^ pol_q);
    edge_seen = sync2_q ^ prev_q;
    event_v   = en_q & src_in & hit & (~mode_q | edge_seen);
    clr_v     = (wr_en && be[0]) ? wdata[N-1:0] : '0;
    flag_d    = (flag_q & ~clr_v) | event_v;
    en_d      = (wr_en && be[1]) ? wdata[8  +: N] : en_q;
    mode_d    = (wr_en && be[2]) ? wdata[16 +: N] : mode_q;
    pol_d     = (wr_en && be[3]) ? wdata[24 +: N] : pol_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      flag_q  <= '0;
      en_q    <= '0;
      mode_q  <= '0;
      pol_q   <= '0;
    end else begin
      sync1_q <= src_pin;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      flag_q  <= flag_d;
      en_q    <= en_d;
      mode_q  <= mode_d;
      pol_q   <= pol_d;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[0  +: N] = flag_q;
    rdata[8  +: N] = en_q;
    rdata[16 +: N] = mode_q;
    rdata[24 +: N] = pol_q;
  end

  assign irq = |(flag_q & en_q);

  AST_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~($past(en_q) & $past(src_in))) == '0));  // R11

  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q != '0));  // R12

  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && be[0] && event_v == '0) |=> ((flag_q & $past(wdata[N-1:0])) == '0));  // R10
endmodule

// File: rtl/gpio_dual_port.sv
module gpio_dual_port
  import gpio_dual_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LANES-1:0]  bus_be,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_oe,
  output logic [PORT_W-1:0] pa_do,
  output logic [PORT_W-1:0] pa_pu,
  output logic [PORT_W-1:0] pa_pd,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_oe,
  output logic [PORT_W-1:0] pb_do,
  output logic [PORT_W-1:0] pb_pu,
  output logic [PORT_W-1:0] pb_pd,
  output logic              irq_o
);
  localparam int FLAT_W = NPORT * PORT_W;

  logic rst_q;
  logic [NPORT-1:0][PORT_W-1:0] p_in, p_rd, p_dir, p_oe, p_do, p_pu, p_pd;
  logic [NPORT-1:0] p_sel;
  logic [FLAT_W-1:0] pins_flat, dir_flat;
  logic [NSRC-1:0] src_pin, src_in;
  logic irq_sel;
  logic [BUS_W-1:0] irq_rd;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q)
  );

  assign p_in[0] = pa_in;
  assign p_in[1] = pb_in;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign p_sel[p] = (bus_addr[ADDR_W-1:3] == 3'(GRP_BASE + p));
    assign pins_flat[p*PORT_W +: PORT_W] = p_in[p];
    assign dir_flat[p*PORT_W +: PORT_W]  = p_dir[p];

    gpio_port_regs #(.W(PORT_W)) u_port (
      .clk     (clk),
      .rst_n   (rst_q),
      .wr_en   (bus_wr && p_sel[p]),
      .reg_sel (bus_addr[2:0]),
      .be      (bus_be),
      .wdata   (bus_wdata),
      .pin_in  (p_in[p]),
      .rdata   (p_rd[p]),
      .dir_o   (p_dir[p]),
      .pad_oe  (p_oe[p]),
      .pad_do  (p_do[p]),
      .pad_pu  (p_pu[p]),
      .pad_pd  (p_pd[p])
    );
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    localparam int IDX = src_pin_idx(k);
    assign src_pin[k] = pins_flat[IDX];
    assign src_in[k]  = ~dir_flat[IDX];
  end

  assign irq_sel = (bus_addr == IRQ_WORD);

  gpio_irq_unit #(.N(NSRC)) u_irq (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr_en   (bus_wr && irq_sel),
    .be      (bus_be),
    .wdata   (bus_wdata),
    .src_pin (src_pin),
    .src_in  (src_in),
    .rdata   (irq_rd),
    .irq     (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (irq_sel) bus_rdata = irq_rd;
    for (int p = 0; p < NPORT; p++) begin
      if (p_sel[p]) bus_rdata = p_rd[p];
    end
  end

  assign pa_oe = p_oe[0];
  assign pa_do = p_do[0];
  assign pa_pu = p_pu[0];
  assign pa_pd = p_pd[0];
  assign pb_oe = p_oe[1];
  assign pb_do = p_do[1];
  assign pb_pu = p_pu[1];
  assign pb_pd = p_pd[1];

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
    (!irq_sel && p_sel == '0) |-> (bus_rdata == '0));  // R13
endmodule

// File: tb/gpio_dual_port_tb.sv
module gpio_dual_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pa_in = '0, pb_in = '0;
  logic [31:0] pa_oe, pa_do, pa_pu, pa_pd, pb_oe, pb_do, pb_pu, pb_pd;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_dual_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_oe(pa_oe), .pa_do(pa_do), .pa_pu(pa_pu), .pa_pd(pa_pd),
    .pb_in(pb_in), .pb_oe(pb_oe), .pb_do(pb_do), .pb_pu(pb_pu), .pb_pd(pb_pd),
    .irq_o(irq_o)
  );

  // Behavioural reference model
  logic [31:0] m_dir[2], m_out[2], m_pu[2], m_pd[2], m_drv[2], m_smt[2];
  logic [7:0]  m_flag, m_en, m_mode, m_pol;
  logic [63:0] h1, h2, h3;
  int src_pos[8] = '{2, 3, 4, 35, 36, 43, 44, 47};

  function automatic logic [31:0] lane_mask(input logic [3:0] b);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{b[i]}};
    return m;
  endfunction

  function automatic logic [31:0] model_rd(input logic [5:0] a);
    int p;
    if (a == 6'd7) return {m_pol, m_mode, m_en, m_flag};
    if (a[5:3] != 3'd2 && a[5:3] != 3'd3) return 32'h0;
    p = (a[5:3] == 3'd3) ? 1 : 0;
    case (a[2:0])
      3'd0: return m_dir[p];
      3'd1: return p ? pb_in : pa_in;
      3'd2: return m_out[p];
      3'd4: return m_pu[p];
      3'd5: return m_pd[p];
      3'd6: return m_drv[p];
      3'd7: return m_smt[p];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        m_dir[p] = 0; m_out[p] = 0; m_pu[p] = 0; m_pd[p] = 0;
        m_drv[p] = 0; m_smt[p] = 32'hFFFF_FFFF;
      end
      m_flag = 0; m_en = 0; m_mode = 0; m_pol = 0;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      logic [7:0]  ev, clr;
      logic [63:0] dflat;
      logic [31:0] mk;
      int p;
      dflat = {m_dir[1], m_dir[0]};
      for (int k = 0; k < 8; k++) begin
        bit lvl_ok, edg;
        lvl_ok = (h2[src_pos[k]] == m_pol[k]);
        edg    = (h2[src_pos[k]] != h3[src_pos[k]]);
        ev[k]  = m_en[k] && !dflat[src_pos[k]] && lvl_ok && (!m_mode[k] || edg);
      end
      clr = (bus_wr && bus_addr == 6'd7 && bus_be[0]) ? bus_wdata[7:0] : 8'h0;
      m_flag = (m_flag & ~clr) | ev;
      mk = lane_mask(bus_be);
      if (bus_wr && bus_addr == 6'd7) begin
        if (bus_be[1]) m_en   = bus_wdata[15:8];
        if (bus_be[2]) m_mode = bus_wdata[23:16];
        if (bus_be[3]) m_pol  = bus_wdata[31:24];
      end
      if (bus_wr && (bus_addr[5:3] == 3'd2 || bus_addr[5:3] == 3'd3)) begin
        p = (bus_addr[5:3] == 3'd3) ? 1 : 0;
        case (bus_addr[2:0])
          3'd0: m_dir[p] = (m_dir[p] & ~mk) | (bus_wdata & mk);
          3'd2: m_out[p] = (m_out[p] & ~mk) | (bus_wdata & mk);
          3'd3: m_out[p] = m_out[p] & ~(bus_wdata & mk);
          3'd4: m_pu[p]  = (m_pu[p] & ~mk) | (bus_wdata & mk);
          3'd5: m_pd[p]  = (m_pd[p] & ~mk) | (bus_wdata & mk);
          3'd6: m_drv[p] = (m_drv[p] & ~mk) | (bus_wdata & mk);
          3'd7: m_smt[p] = (m_smt[p] & ~mk) | (bus_wdata & mk);
          default: ;
        endcase
      end
      h3 = h2; h2 = h1; h1 = {pb_in, pa_in};
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check("R2/R3/R13 rdata", bus_rdata, model_rd(bus_addr));
      check("R5 pa_oe", pa_oe, m_dir[0] & ~(m_pd[0] & m_out[0]));
      check("R5 pb_oe", pb_oe, m_dir[1] & ~(m_pd[1] & m_out[1]));
      check("R5 pa_do", pa_do, m_out[0]);
      check("R6 pa_pd", pa_pd, m_pd[0] & ~m_dir[0]);
      check("R6 pb_pu", pb_pu, m_pu[1]);
      check("R12 irq", {31'h0, irq_o}, {31'h0, |(m_flag & m_en)});
    end
  end

  task automatic wr(input logic [5:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_be = b; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, exp);
  endtask

  task automatic setpins(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk); #1;
    pa_in = a; pb_in = b;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); #1 rst_n = 1'b1;
    idle(4);
    // R1 reset state
    rd_chk(6'd23, 32'hFFFF_FFFF, "R1 smt A");
    rd_chk(6'd16, 32'h0, "R1 dir A");
    rd_chk(6'd26, 32'h0, "R1 out B");
    rd_chk(6'd7, 32'h0, "R1 irq regs");
    check("R1 irq_o", {31'h0, irq_o}, 32'h0);
    // R5/R6 pad controls
    wr(6'd16, 4'hF, 32'h0000_00F0);
    wr(6'd18, 4'hF, 32'hFFFF_00A0);
    wr(6'd21, 4'hF, 32'h0000_0031);
    idle(1);
    check("R5 pa_oe open-drain", pa_oe, 32'h0000_00D0);
    check("R6 pa_pd input only", pa_pd, 32'h0000_0001);
    // R4 output clear
    wr(6'd19, 4'b0001, 32'h0000_00A0);
    rd_chk(6'd18, 32'hFFFF_0000, "R4 out after clear");
    rd_chk(6'd19, 32'h0, "R4 clr reads zero");
    // R2 byte lanes
    wr(6'd28, 4'b0010, 32'hFFFF_FFFF);
    rd_chk(6'd28, 32'h0000_FF00, "R2 pu B byte lane");
    check("R6 pb_pu", pb_pu, 32'h0000_FF00);
    // R3 input view
    setpins(32'hA5A5_0F03, 32'h1234_0567);
    rd_chk(6'd17, 32'hA5A5_0F03, "R3 pin A");
    rd_chk(6'd25, 32'h1234_0567, "R3 pin B");
    setpins(32'h0, 32'h0);
    idle(4);
    // R13 reserved and read-only
    wr(6'd0, 4'hF, 32'hFFFF_FFFF);
    wr(6'h30, 4'hF, 32'hFFFF_FFFF);
    wr(6'd17, 4'hF, 32'hFFFF_FFFF);
    rd_chk(6'd0, 32'h0, "R13 reserved low");
    rd_chk(6'h30, 32'h0, "R13 reserved high");
    rd_chk(6'd17, 32'h0, "R13 pin write ignored");
    rd_chk(6'd16, 32'h0000_00F0, "R13 dir untouched");
    // R7/R9 rising edge on source 0 (A2)
    wr(6'd7, 4'b1110, 32'hF709_0100);
    setpins(32'h0000_0004, 32'h0);
    idle(5);
    rd_chk(6'd7, 32'hF709_0101, "R9 rising edge flag");
    check("R12 irq high", {31'h0, irq_o}, 32'h1);
    wr(6'd7, 4'b0001, 32'h0000_0001);
    rd_chk(6'd7, 32'hF709_0100, "R10 w1c");
    // R8 level source 1 (A3), high level
    wr(6'd7, 4'b0010, 32'h0000_0200);
    setpins(32'h0000_000C, 32'h0);
    idle(5);
    wr(6'd7, 4'b0001, 32'h0000_00FF);
    rd_chk(6'd7, 32'hF709_0202, "R8 level re-sets after clear");
    setpins(32'h0000_0004, 32'h0);
    idle(4);
    wr(6'd7, 4'b0001, 32'h0000_0002);
    rd_chk(6'd7, 32'hF709_0200, "R8 level released");
    // R11 gating by direction: source 5 (B11)
    wr(6'd24, 4'hF, 32'h0000_0800);
    wr(6'd7, 4'b0010, 32'h0000_2000);
    setpins(32'h0000_0004, 32'h0000_0800);
    idle(5);
    rd_chk(6'd7, 32'hF709_2000, "R11 output pin no flag");
    wr(6'd24, 4'hF, 32'h0);
    idle(2);
    rd_chk(6'd7, 32'hF709_2020, "R11 input pin sets flag");
    wr(6'd7, 4'b0010, 32'h0);
    rd_chk(6'd7, 32'hF709_0020, "R12 flag kept after disable");
    check("R12 irq low when disabled", {31'h0, irq_o}, 32'h0);
    setpins(32'h0000_0004, 32'h0);
    wr(6'd7, 4'b0001, 32'h0000_0020);
    // R9 falling edge on source 3 (B3)
    wr(6'd7, 4'b0010, 32'h0000_0800);
    setpins(32'h0000_0004, 32'h0000_0008);
    idle(5);
    rd_chk(6'd7, 32'hF709_0800, "R9 rising ignored by falling source");
    setpins(32'h0000_0004, 32'h0);
    idle(5);
    rd_chk(6'd7, 32'hF709_0808, "R9 falling edge flag");
    wr(6'd7, 4'b0011, 32'h0000_0108);
    // R10 clear versus event collision on source 0
    for (int off = 0; off < 5; off++) begin
      setpins(32'h0, 32'h0);
      idle(5);
      wr(6'd7, 4'b0001, 32'h0000_00FF);
      setpins(32'h0000_0004, 32'h0);
      idle(off);
      wr(6'd7, 4'b0001, 32'h0000_0001);
      idle(3);
      rd_chk(6'd7, (off <= 1) ? 32'hF709_0101 : 32'hF709_0100, "R10 clear vs event");
    end
    idle(2);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule